// File: doc/BRIEF.md
# Dual-Clock 9-Bit FIFO With Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words. The write side and the read side run from separate clocks, and those clocks need not be related. Words go into a dual-port storage array. The block reports four active-low status flags. Empty and almost-empty belong to the read clock. Full and almost-full belong to the write clock. Each almost flag is measured as a distance from its own boundary, and that distance can be changed at run time.

One write-side pin has two roles. Its level while reset is held decides how it is used afterwards. If it is HIGH, it acts as a second write enable, and both thresholds stay at their default distance of 7. If it is LOW, it acts as the load strobe of a separate offset-register block. That block supplies the two distances through the `ae_offset` and `af_offset` inputs. While the strobe is LOW, FIFO reads are blocked, so that the offset block can use the read port. The data output has its own enable and floats when that enable is HIGH. A parameter lets both domains be built from one clock. When it is set, the pointer synchronizers are left out.

Top module: `fifo9_dc`

## Requirements
- R1: While `rst_n` is LOW and after its release, before any write, `empty_n`=0, `almost_empty_n`=0, `full_n`=1 and `almost_full_n`=1. The output register holds 0 (seen on `dout` with `oe_n`=0).
- R2: `offset_mode` takes the inverse of the `wen2_ld` level seen during reset: 0 means two write enables, 1 means offset-load control. It keeps that value until the next reset.
- R3: A word is written only at a write-clock edge where `wen1_n`=0 and `wen2_ld`=1. Any other combination writes nothing.
- R4: A word is read only at a read-clock edge where `ren1_n`=0 and `ren2_n`=0 and, when `offset_mode`=1, `wen2_ld`=1. Otherwise the output register keeps its word.
- R5: Write requests made while `full_n`=0 are dropped. No stored word is overwritten.
- R6: Read requests made while `empty_n`=0 are dropped. The output register keeps its word.
- R7: Once the flags have settled, `almost_empty_n`=0 exactly when the word count is n or less. n is `ae_offset` when `offset_mode`=1 and 7 otherwise.
- R8: Once the flags have settled, `almost_full_n`=0 exactly when the word count is DEPTH-m or more. m is `af_offset` when `offset_mode`=1 and 7 otherwise.
- R9: `full_n` goes to 0 after exactly DEPTH accepted writes with no reads. Once the flags have settled, `empty_n`=0 exactly when the count is 0.
- R10: Words leave the FIFO in the order they were written, with their values unchanged.
- R11: `dout` is high-impedance on all 9 bits while `oe_n`=1. While `oe_n`=0 it drives the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset; each domain releases it synchronously |
| din | input | 9 | Write data |
| wen1_n | input | 1 | Active-low write enable |
| wen2_ld | input | 1 | Second active-high write enable, or offset-load strobe; role chosen during reset |
| ren1_n | input | 1 | Active-low read enable |
| ren2_n | input | 1 | Active-low read enable |
| oe_n | input | 1 | Active-low output enable |
| ae_offset | input | AW | Almost-empty distance from the offset block |
| af_offset | input | AW | Almost-full distance from the offset block |
| dout | output | 9 | Read data, tri-state |
| empty_n | output | 1 | LOW when empty (read domain) |
| almost_empty_n | output | 1 | LOW at n words or fewer (read domain) |
| full_n | output | 1 | LOW when full (write domain) |
| almost_full_n | output | 1 | LOW at DEPTH-m words or more (write domain) |
| offset_mode | output | 1 | 1 when `wen2_ld` is the offset-load strobe |

## Verification
The bench builds the block with DEPTH=256 and SINGLE_CLOCK=0. The write clock has a 10 ns period and the read clock a 14 ns period, so the Gray pointers are always crossed between unrelated clock edges. A 256-word array is small enough to fill completely. That puts every boundary count (0, n, n+1, DEPTH-m-1, DEPTH-m and DEPTH) within reach, both with the default distance of 7 and with programmed distances of 20 and 30. Because the read clock is slower than the write clock, random traffic builds up a backlog, so the flags move in both directions many times.

// File: rtl/fifo9_pkg.sv
package fifo9_pkg;
  localparam int DATA_W = 9;
  localparam int DEF_OFS = 7;

  // Gray to binary for pointers up to 16 bits.
  function automatic logic [15:0] gray_to_bin(input logic [15:0] g);
    logic [15:0] b;
    b[15] = g[15];
    for (int i = 14; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/fifo9_rst_sync.sv
module fifo9_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/fifo9_sync.sv
module fifo9_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/fifo9_wside.sv
module fifo9_wside #(
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_req,
  input  logic [AW:0]   rgray_s,
  input  logic [AW-1:0] af_ofs,
  output logic          wr_en,
  output logic [AW:0]   wbin,
  output logic [AW:0]   wgray,
  output logic          full_n,
  output logic          almost_full_n
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] CAP = PW'(1 << AW);

  logic [PW-1:0] bin_q, bin_d, gray_q, gray_d, rbin_s, level_d, af_lim;
  logic          full_q, full_d, af_q, af_d;

  always_comb begin
    wr_en   = wr_req & full_q;
    bin_d   = bin_q + {{AW{1'b0}}, wr_en};
    gray_d  = bin_d ^ (bin_d >> 1);
    rbin_s  = PW'(fifo9_pkg::gray_to_bin(16'(rgray_s)));
    level_d = bin_d - rbin_s;
    af_lim  = CAP - {1'b0, af_ofs};
    full_d  = (level_d != CAP);
    af_d    = (level_d < af_lim);
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
      full_q <= 1'b1;
      af_q   <= 1'b1;
    end else begin
      if (wr_en) begin
        bin_q  <= bin_d;
        gray_q <= gray_d;
      end
      full_q <= full_d;
      af_q   <= af_d;
    end
  end

  assign wbin          = bin_q;
  assign wgray         = gray_q;
  assign full_n        = full_q;
  assign almost_full_n = af_q;
endmodule

// File: rtl/fifo9_rside.sv
module fifo9_rside #(
  parameter int AW = 8,
  parameter int W  = 9
) (
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_req,
  input  logic [AW:0]   wgray_s,
  input  logic [AW-1:0] ae_ofs,
  input  logic [W-1:0]  rdata,
  output logic [AW:0]   rbin,
  output logic [AW:0]   rgray,
  output logic [W-1:0]  dout_q,
  output logic          empty_n,
  output logic          almost_empty_n
);
  localparam int PW = AW + 1;

  logic [PW-1:0] bin_q, bin_d, gray_q, gray_d, wbin_s, level_d;
  logic [W-1:0]  data_q, data_d;
  logic          rd_en, empty_q, empty_d, ae_q, ae_d;

  always_comb begin
    rd_en   = rd_req & empty_q;
    bin_d   = bin_q + {{AW{1'b0}}, rd_en};
    gray_d  = bin_d ^ (bin_d >> 1);
    wbin_s  = PW'(fifo9_pkg::gray_to_bin(16'(wgray_s)));
    level_d = wbin_s - bin_d;
    empty_d = (level_d != '0);
    ae_d    = (level_d > {1'b0, ae_ofs});
    data_d  = rd_en ? rdata : data_q;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      bin_q   <= '0;
      gray_q  <= '0;
      data_q  <= '0;
      empty_q <= 1'b0;
      ae_q    <= 1'b0;
    end else begin
      if (rd_en) begin
        bin_q  <= bin_d;
        gray_q <= gray_d;
      end
      data_q  <= data_d;
      empty_q <= empty_d;
      ae_q    <= ae_d;
    end
  end

  assign rbin           = bin_q;
  assign rgray          = gray_q;
  assign dout_q         = data_q;
  assign empty_n        = empty_q;
  assign almost_empty_n = ae_q;
endmodule

// File: rtl/fifo9_dc.sv
module fifo9_dc #(
  parameter int DEPTH        = 256,
  parameter bit SINGLE_CLOCK = 1'b0,
  parameter int AW           = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic [8:0]    din,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  logic          ren1_n,
  input  logic          ren2_n,
  input  logic          oe_n,
  input  logic [AW-1:0] ae_offset,
  input  logic [AW-1:0] af_offset,
  output logic [8:0]    dout,
  output logic          empty_n,
  output logic          almost_empty_n,
  output logic          full_n,
  output logic          almost_full_n,
  output logic          offset_mode
);
  localparam int W  = fifo9_pkg::DATA_W;
  localparam int PW = AW + 1;

  logic          wrst_n, rrst_n, mode_q, wr_en, wr_req, rd_req;
  logic [PW-1:0] w_bin, w_gray, r_bin, r_gray, w_gray_s, r_gray_s;
  logic [AW-1:0] ae_eff, af_eff;
  logic [W-1:0]  r_dout, rdata;
  logic [W-1:0]  mem [DEPTH];

  fifo9_rst_sync u_wrst (.clk(wclk), .arst_n(rst_n), .srst_n(wrst_n));
  fifo9_rst_sync u_rrst (.clk(rclk), .arst_n(rst_n), .srst_n(rrst_n));

  // Pin role is sampled on every write-clock edge while reset is held.
  always_ff @(posedge wclk) begin
    if (!rst_n) mode_q <= ~wen2_ld;
  end

  always_comb begin
    wr_req = ~wen1_n & wen2_ld;
    rd_req = ~ren1_n & ~ren2_n & (~mode_q | wen2_ld);
    ae_eff = mode_q ? ae_offset : AW'(fifo9_pkg::DEF_OFS);
    af_eff = mode_q ? af_offset : AW'(fifo9_pkg::DEF_OFS);
  end

  generate
    if (SINGLE_CLOCK) begin : g_one_clk
      assign w_gray_s = w_gray;
      assign r_gray_s = r_gray;
    end else begin : g_two_clk
      fifo9_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(w_gray), .q(w_gray_s));
      fifo9_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(r_gray), .q(r_gray_s));
    end
  endgenerate

  fifo9_wside #(.AW(AW)) u_wside (
    .wclk(wclk), .wrst_n(wrst_n), .wr_req(wr_req), .rgray_s(r_gray_s),
    .af_ofs(af_eff), .wr_en(wr_en), .wbin(w_bin), .wgray(w_gray),
    .full_n(full_n), .almost_full_n(almost_full_n)
  );

  always_ff @(posedge wclk) begin
    if (wr_en) mem[w_bin[AW-1:0]] <= din;
  end

  assign rdata = mem[r_bin[AW-1:0]];

  fifo9_rside #(.AW(AW), .W(W)) u_rside (
    .rclk(rclk), .rrst_n(rrst_n), .rd_req(rd_req), .wgray_s(w_gray_s),
    .ae_ofs(ae_eff), .rdata(rdata), .rbin(r_bin), .rgray(r_gray),
    .dout_q(r_dout), .empty_n(empty_n), .almost_empty_n(almost_empty_n)
  );

  assign dout        = oe_n ? {W{1'bz}} : r_dout;
  assign offset_mode = mode_q;
endmodule

// File: rtl/fifo9_dc_chk.sv
module fifo9_dc_chk #(
  parameter int PW = 9
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          wen1_n,
  input logic          wen2_ld,
  input logic          ren1_n,
  input logic          ren2_n,
  input logic          full_n,
  input logic          almost_full_n,
  input logic          empty_n,
  input logic          almost_empty_n,
  input logic          offset_mode,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] rbin,
  input logic [PW-1:0] wgray,
  input logic [8:0]    dout_q
);
  p_mode_hold_r2: assert property (@(posedge wclk) disable iff (!rst_n)
    $stable(offset_mode));

  p_hold_r4: assert property (@(posedge rclk) disable iff (!rst_n)
    (ren1_n || ren2_n) |=> $stable(dout_q));

  p_no_overflow_r5: assert property (@(posedge wclk) disable iff (!rst_n)
    (!full_n && !wen1_n && wen2_ld) |=> $stable(wbin));

  p_no_underflow_r6: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> $stable(rbin));

  p_empty_in_ae_r7: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |-> !almost_empty_n);

  p_full_in_af_r8: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |-> !almost_full_n);

  p_gray_step_r10: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

bind fifo9_dc fifo9_dc_chk #(.PW(PW)) i_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
  .ren1_n(ren1_n), .ren2_n(ren2_n), .full_n(full_n), .almost_full_n(almost_full_n),
  .empty_n(empty_n), .almost_empty_n(almost_empty_n), .offset_mode(offset_mode),
  .wbin(w_bin), .rbin(r_bin), .wgray(w_gray), .dout_q(r_dout)
);

// File: tb/test_fifo9_dc.sv
module test_fifo9_dc;
  localparam int DEPTH = 256;
  localparam int AW    = 8;

  logic wclk = 1'b0, rclk = 1'b0;
  logic rst_n, wen1_n, wen2_ld, ren1_n, ren2_n, oe_n;
  logic [8:0] din, dout;
  logic [AW-1:0] ae_offset, af_offset;
  logic empty_n, almost_empty_n, full_n, almost_full_n, offset_mode;

  int checks = 0, fails = 0;
  logic [8:0] q[$];
  logic [8:0] last_out;

  always #5 wclk = ~wclk;
  always #7 rclk = ~rclk;

  fifo9_dc #(.DEPTH(DEPTH), .SINGLE_CLOCK(1'b0)) i_fifo9_dc (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .din(din), .wen1_n(wen1_n),
    .wen2_ld(wen2_ld), .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n),
    .ae_offset(ae_offset), .af_offset(af_offset), .dout(dout),
    .empty_n(empty_n), .almost_empty_n(almost_empty_n), .full_n(full_n),
    .almost_full_n(almost_full_n), .offset_mode(offset_mode)
  );

  function automatic bit exp_empty_n(int c);        return c != 0;         endfunction
  function automatic bit exp_full_n(int c);         return c != DEPTH;     endfunction
  function automatic bit exp_ae_n(int c, int n);    return c > n;          endfunction
  function automatic bit exp_af_n(int c, int m);    return c < DEPTH - m;  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
    repeat (8) @(negedge wclk);
  endtask

  task automatic check_flags(string tag, int n, int m);
    int c;
    settle();
    c = q.size();
    chk(empty_n == exp_empty_n(c), {tag, " R9 empty_n"}, empty_n, exp_empty_n(c));
    chk(full_n == exp_full_n(c), {tag, " R9 full_n"}, full_n, exp_full_n(c));
    chk(almost_empty_n == exp_ae_n(c, n), {tag, " R7 almost_empty_n"}, almost_empty_n, exp_ae_n(c, n));
    chk(almost_full_n == exp_af_n(c, m), {tag, " R8 almost_full_n"}, almost_full_n, exp_af_n(c, m));
  endtask

  task automatic wr(logic [8:0] d);
    bit acc;
    @(negedge wclk);
    din = d; wen1_n = 1'b0; wen2_ld = 1'b1;
    acc = full_n;
    @(negedge wclk);
    wen1_n = 1'b1;
    if (acc) q.push_back(d);
  endtask

  task automatic rd();
    bit acc;
    logic [8:0] e;
    @(negedge rclk);
    ren1_n = 1'b0; ren2_n = 1'b0;
    acc = empty_n;
    @(negedge rclk);
    ren1_n = 1'b1; ren2_n = 1'b1;
    if (acc) begin
      e = q.pop_front();
      chk(dout === e, "R10 read order", dout, e);
      last_out = e;
    end else begin
      chk(dout === last_out, "R6 read while empty holds", dout, last_out);
    end
  endtask

  task automatic fill_to(int k);
    while (q.size() < k) wr(9'($urandom));
  endtask

  task automatic drain_to(int k);
    while (q.size() > k) rd();
  endtask

  task automatic do_reset(logic pin);
    rst_n = 1'b0; wen2_ld = pin; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    repeat (4) @(negedge wclk);
    chk(empty_n == 1'b0, "R1 empty_n in reset", empty_n, 0);
    chk(almost_empty_n == 1'b0, "R1 almost_empty_n in reset", almost_empty_n, 0);
    chk(full_n == 1'b1, "R1 full_n in reset", full_n, 1);
    chk(almost_full_n == 1'b1, "R1 almost_full_n in reset", almost_full_n, 1);
    chk(dout === 9'd0, "R1 output register cleared", dout, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge wclk);
    wen2_ld = 1'b1;
    q.delete();
    last_out = 9'd0;
    settle();
    chk(offset_mode == ~pin, "R2 mode from reset level", offset_mode, ~pin);
  endtask

  initial begin
    #2000000;
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wen1_n = 1'b1; wen2_ld = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    oe_n = 1'b0; din = '0; ae_offset = 8'd20; af_offset = 8'd30;
    void'($urandom(32'd4711));

    // Two-enable mode: thresholds fixed at 7 regardless of offset inputs.
    do_reset(1'b1);
    check_flags("A count0", 7, 7);
    // R3: wen2_ld LOW blocks the write in this mode.
    @(negedge wclk); din = 9'h155; wen1_n = 1'b0; wen2_ld = 1'b0;
    repeat (3) @(negedge wclk);
    wen1_n = 1'b1; wen2_ld = 1'b1;
    check_flags("A R3 no write", 7, 7);
    fill_to(7);         check_flags("A count n", 7, 7);
    fill_to(8);         check_flags("A count n+1", 7, 7);
    fill_to(DEPTH - 8); check_flags("A count D-m-1", 7, 7);
    fill_to(DEPTH - 7); check_flags("A count D-m", 7, 7);
    fill_to(DEPTH);     check_flags("A count D", 7, 7);
    // R5: write attempt while full is dropped.
    wr(9'h1AA);
    chk(q.size() == DEPTH, "R5 write dropped when full", q.size(), DEPTH);
    rd();
    // R4: one read enable inactive holds the output.
    @(negedge rclk); ren1_n = 1'b0; ren2_n = 1'b1;
    repeat (3) @(negedge rclk);
    ren1_n = 1'b1;
    chk(dout === last_out, "R4 single enable holds", dout, last_out);
    drain_to(0);
    check_flags("A drained", 7, 7);
    rd();
    // R11: output float.
    oe_n = 1'b1; #1;
    chk(dout === 9'bzzzzzzzzz, "R11 high impedance", dout, 0);
    oe_n = 1'b0; #1;
    chk(dout === last_out, "R11 drives register", dout, last_out);

    // Offset-load mode with n=20, m=30.
    do_reset(1'b0);
    check_flags("B count0", 20, 30);
    fill_to(20);        check_flags("B count n", 20, 30);
    fill_to(21);        check_flags("B count n+1", 20, 30);
    fill_to(DEPTH - 31); check_flags("B count D-m-1", 20, 30);
    fill_to(DEPTH - 30); check_flags("B count D-m", 20, 30);
    fill_to(DEPTH);     check_flags("B count D", 20, 30);
    rd();
    // R4: load strobe LOW blocks FIFO reads in this mode.
    @(negedge rclk); wen2_ld = 1'b0; ren1_n = 1'b0; ren2_n = 1'b0;
    repeat (3) @(negedge rclk);
    ren1_n = 1'b1; ren2_n = 1'b1; wen2_ld = 1'b1;
    chk(dout === last_out, "R4 load strobe blocks read", dout, last_out);
    check_flags("B R4 count kept", 20, 30);
    drain_to(100);

    // Random traffic.
    for (int i = 0; i < 1500; i++) begin
      if (($urandom % 100) < 55) wr(9'($urandom));
      else rd();
      if ((i % 300) == 299) check_flags("B random", 20, 30);
    end
    drain_to(0);
    check_flags("B final", 20, 30);
    finish_run();
  end
endmodule